// File: doc/BRIEF.md
# Auto-Stepping Display Data RAM

This block holds the data shown on a small character or graphic panel, 10 columns by 10 rows of 8-bit words, behind a command-style port. A host issues one of four commands per cycle: load the column (X) pointer, load the row (Y) pointer, store a word, or fetch a word. Every store or fetch uses the current X/Y location. After the access, the pointers advance without further commands, so a host can stream a whole region after setting the start point once, with the two pointers loaded in either order.

A mode input picks which pointer steps on every access. The other pointer moves only when the stepping pointer wraps. A width select chooses 8-bit or 6-bit words. This changes both the data masking and the column range. A two-bit duty code tells the block how many rows are actually shown. Rows beyond that limit can still hold data, but a row wrap that happens there does not carry into X. Reset returns the pointers and the read port to zero and leaves the stored words as they were.

Top module: `disp_ram_autoinc`

## Requirements
- R1: When `cmd_valid` is high, `cmd` selects the operation: 00 loads X, 01 loads Y, 10 stores `din`, 11 fetches a word. When `cmd_valid` is low, nothing changes and `dout_valid` is low on the next cycle.
- R2: A load of X takes `din[3:0]` and ignores `din[7:4]`. A value above the column limit is clamped to that limit. The column limit is 7 when `narrow` = 0 and 9 when `narrow` = 1.
- R3: A load of Y takes `din[3:0]` and clamps it to the row limit. The row limit is 9 when `row_major` = 1 and equals the column limit when `row_major` = 0.
- R4: With `row_major` = 0, each store or fetch advances X by one. When X is at or above the column limit it returns to 0, and Y then advances, returning to 0 from the row limit.
- R5: With `row_major` = 1, each store or fetch advances Y by one. When Y is at 9 it returns to 0 and X advances, returning to 0 from the column limit.
- R6: The shown rows are 0 to 7 when `duty` = 00 and 0 to 9 for any other code. A Y wrap made at a row that is not shown leaves X unchanged.
- R7: A store writes the word at the current (X, Y). When `narrow` = 1, bits 7 and 6 are stored as 0.
- R8: A fetch sets `dout_valid` high on the next cycle, with `dout` holding the word at the X/Y location in use before the pointers advanced. When `narrow` was 1 at the fetch, `dout[7:6]` are 0. `dout` keeps its last value until the next fetch.
- R9: While `rst_n` is low, X, Y, `dout` and `dout_valid` are 0. Stored words keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pointers and read port |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 2 | Command code (see R1) |
| din | input | 8 | Pointer value or data word |
| narrow | input | 1 | 1 selects 6-bit words and a 0..9 column range |
| duty | input | 2 | Shown-row code |
| row_major | input | 1 | 1 makes Y the pointer that steps on every access |
| dout | output | 8 | Fetched word |
| dout_valid | output | 1 | `dout` was updated by a fetch in the previous cycle |

## Verification
A single access both moves data and moves the pointers. At a wrap point, the same edge also carries one pointer into the other or suppresses that carry. The key case is a fetch at X = 9, Y = 9 in row-major mode. There the returned word must come from the old location while Y clears and X either clears or holds, depending on the duty code. The bench walks every location in both stepping modes, with the carry allowed and with it suppressed, then issues thousands of random command sequences with mode changes mixed in. A behavioural model predicts `dout` and `dout_valid` for every cycle and compares them, so any pointer error shows up as a wrong word on a later fetch.

// File: rtl/disp_ram_autoinc.sv
module disp_ram_autoinc #(
  parameter int COLS       = 10,
  parameter int ROWS       = 10,
  parameter int WIDE_XMAX  = 7,
  parameter int SHORT_ROWS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic [7:0] din,
  input  logic       narrow,
  input  logic [1:0] duty,
  input  logic       row_major,
  output logic [7:0] dout,
  output logic       dout_valid
);
  localparam int DEPTH = COLS * ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [3:0] XMAX_N = 4'(COLS - 1);
  localparam logic [3:0] XMAX_W = 4'(WIDE_XMAX);
  localparam logic [3:0] YMAX   = 4'(ROWS - 1);

  logic [3:0] x_q, y_q, x_d, y_d;
  logic [7:0] mem [DEPTH];

  wire [3:0] x_lim    = narrow ? XMAX_N : XMAX_W;
  wire [3:0] y_lim    = row_major ? YMAX : x_lim;
  wire [4:0] shown    = (duty == 2'b00) ? 5'(SHORT_ROWS) : 5'(ROWS);
  wire       access   = cmd_valid && cmd[1];
  wire       do_wr    = cmd_valid && (cmd == 2'b10);
  wire       do_rd    = cmd_valid && (cmd == 2'b11);
  wire [AW-1:0] addr  = AW'(x_q) * AW'(ROWS) + AW'(y_q);
  wire [7:0] wdata    = narrow ? {2'b00, din[5:0]} : din;
  wire [7:0] rraw     = mem[addr];
  wire [7:0] rdata    = narrow ? {2'b00, rraw[5:0]} : rraw;
  wire [3:0] x_step   = (x_q >= x_lim) ? 4'd0 : x_q + 4'd1;
  wire [3:0] y_step   = (y_q >= y_lim) ? 4'd0 : y_q + 4'd1;
  wire       x_wrap   = x_q >= x_lim;
  wire       y_wrap   = y_q >= y_lim;
  wire       hidden   = {1'b0, y_q} >= shown;
  wire [3:0] x_load   = (din[3:0] > x_lim) ? x_lim : din[3:0];
  wire [3:0] y_load   = (din[3:0] > y_lim) ? y_lim : din[3:0];

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (cmd_valid && cmd == 2'b00) x_d = x_load;
    if (cmd_valid && cmd == 2'b01) y_d = y_load;
    if (access) begin
      if (row_major) begin
        y_d = y_step;
        if (y_wrap && !hidden) x_d = x_step;
      end else begin
        x_d = x_step;
        if (x_wrap) y_d = y_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q        <= '0;
      y_q        <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      x_q        <= x_d;
      y_q        <= y_d;
      dout_valid <= do_rd;
      if (do_rd) dout <= rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[addr] <= wdata;
  end
endmodule

module disp_ram_autoinc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd,
  input logic [7:0] din,
  input logic       narrow,
  input logic [1:0] duty,
  input logic       row_major,
  input logic [7:0] dout,
  input logic       dout_valid,
  input logic [3:0] x_q,
  input logic [3:0] y_q
);
  wire       acc  = cmd_valid && cmd[1];
  wire [3:0] xl   = narrow ? 4'd9 : 4'd7;

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= 4'd9 && y_q <= 4'd9);

  assert_x_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b00 && din[3:0] <= xl) |=> x_q == $past(din[3:0]));

  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !row_major && x_q < xl) |=> (x_q == $past(x_q) + 4'd1) && (y_q == $past(y_q)));

  assert_col_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !row_major && x_q == xl) |=> x_q == 4'd0);

  assert_row_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && row_major && y_q == 4'd9 && duty != 2'b00 && x_q < xl) |=> (y_q == 4'd0) && (x_q == $past(x_q) + 4'd1));

  assert_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && row_major && y_q == 4'd9 && duty == 2'b00) |=> (y_q == 4'd0) && $stable(x_q));

  assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 2'b11) |=> dout_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd == 2'b11) |=> !dout_valid);

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && $past(narrow)) |-> dout[7:6] == 2'b00);
endmodule

bind disp_ram_autoinc disp_ram_autoinc_chk u_chk (.*);

// File: tb/disp_ram_autoinc_tb.sv
module disp_ram_autoinc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [7:0] din = 8'h00;
  logic       narrow = 1'b0;
  logic [1:0] duty = 2'b01;
  logic       row_major = 1'b0;
  logic [7:0] dout;
  logic       dout_valid;

  always #2 clk = ~clk;

  disp_ram_autoinc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .din(din),
    .narrow(narrow), .duty(duty), .row_major(row_major),
    .dout(dout), .dout_valid(dout_valid)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int mx = 0, my = 0;
  int ram [100];
  bit seen [100];
  int exp_dout = 0;
  bit exp_valid = 1'b0;
  bit exp_known = 1'b1;
  string req = "R1";

  function automatic int clampv(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic compare();
    checks++;
    if (dout_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s dout_valid actual=%0b expected=%0b", req, dout_valid, exp_valid);
    end
    if (exp_known) begin
      checks++;
      if (dout !== 8'(exp_dout)) begin
        errors++;
        $display("FAIL %s dout actual=%02h expected=%02h (x=%0d y=%0d)", req, dout, exp_dout, mx, my);
      end
    end
  endtask

  task automatic cyc(input bit v, input logic [1:0] c, input logic [7:0] d);
    int xl, yl, sh, a;
    cmd_valid = v; cmd = c; din = d;
    xl = narrow ? 9 : 7;
    yl = row_major ? 9 : xl;
    sh = (duty == 2'b00) ? 8 : 10;
    exp_valid = 1'b0;
    if (v) begin
      case (c)
        2'b00: mx = clampv(int'(d[3:0]), xl);
        2'b01: my = clampv(int'(d[3:0]), yl);
        default: begin
          a = mx * 10 + my;
          if (c == 2'b10) begin
            ram[a] = narrow ? int'(d[5:0]) : int'(d);
            seen[a] = 1'b1;
          end else begin
            exp_valid = 1'b1;
            exp_known = seen[a];
            exp_dout = narrow ? (ram[a] & 63) : ram[a];
          end
          if (row_major) begin
            if (my >= 9) begin
              my = 0;
              if (a % 10 < sh) mx = (mx >= xl) ? 0 : mx + 1;
            end else my++;
          end else begin
            if (mx >= xl) begin
              mx = 0;
              my = (my >= yl) ? 0 : my + 1;
            end else mx++;
          end
        end
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    mx = 0; my = 0;
    exp_valid = 1'b0; exp_dout = 0; exp_known = 1'b1;
    @(negedge clk);
    req = "R9";
    compare();
    rst_n = 1'b1;
  endtask

  task automatic setxy(input int x, input int y, input bit y_first);
    if (y_first) begin cyc(1, 2'b01, 8'(y)); cyc(1, 2'b00, 8'(x)); end
    else begin cyc(1, 2'b00, 8'(x)); cyc(1, 2'b01, 8'(y)); end
  endtask

  initial begin
    for (int i = 0; i < 100; i++) begin ram[i] = 0; seen[i] = 1'b0; end
    @(negedge clk);
    do_reset();

    req = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 2'b11, 8'hFF);

    req = "R7";
    narrow = 1'b1; row_major = 1'b1; duty = 2'b01;
    setxy(0, 0, 0);
    for (int i = 0; i < 100; i++) cyc(1, 2'b10, 8'(i * 37 + 200));
    req = "R5";
    narrow = 1'b0;
    setxy(0, 0, 1);
    for (int i = 0; i < 80; i++) cyc(1, 2'b11, 8'h00);

    req = "R4";
    narrow = 1'b0; row_major = 1'b0;
    setxy(0, 0, 0);
    for (int i = 0; i < 64; i++) cyc(1, 2'b10, 8'(255 - i * 3));
    setxy(5, 6, 1);
    for (int i = 0; i < 70; i++) cyc(1, 2'b11, 8'h00);

    req = "R8";
    narrow = 1'b1;
    setxy(3, 3, 0);
    for (int i = 0; i < 12; i++) cyc(1, 2'b11, 8'h00);

    req = "R2";
    narrow = 1'b0;
    cyc(1, 2'b00, 8'hFC);
    cyc(1, 2'b01, 8'h02);
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b00, 8'hA3);
    cyc(1, 2'b11, 8'h00);

    req = "R3";
    row_major = 1'b1; narrow = 1'b1;
    cyc(1, 2'b00, 8'h01);
    cyc(1, 2'b01, 8'h0F);
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b11, 8'h00);

    req = "R6";
    duty = 2'b00;
    setxy(4, 9, 0);
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b01, 8'h09);
    cyc(1, 2'b10, 8'h5A);
    setxy(4, 9, 1);
    cyc(1, 2'b11, 8'h00);
    req = "R5";
    duty = 2'b10;
    setxy(9, 9, 0);
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b11, 8'h00);

    req = "R9";
    setxy(6, 5, 0);
    do_reset();
    narrow = 1'b0;
    cyc(1, 2'b11, 8'h00);
    cyc(1, 2'b11, 8'h00);

    req = "R1";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) narrow = ~narrow;
      else if (r < 4) row_major = ~row_major;
      else if (r < 6) duty = 2'($urandom_range(0, 3));
      cyc(bit'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule